// File: doc/BRIEF.md
# Endpoint Bank Rotation Tracker

This block keeps the bank bookkeeping for a single USB device endpoint whose packet buffer is divided into one, two or three banks. Firmware works on one bank at a time, called the current bank. It adds bytes to an outgoing packet, or takes bytes from a received one. When a packet is finished, firmware either hands it over for transmission or releases the bank it has emptied, and the current bank then moves on to the next one. The serial engine reports which IN packets completed, which OUT packets arrived and their lengths, and which tokens came in. From this the block decides when a NAK handshake must be returned.

The block holds the current bank index, the count of busy banks, a live byte count for the current bank, one stored length per bank, a sticky NAK-on-OUT flag and a sticky user error flag. When the current bank moves on, the live byte count takes the stored length of the bank it moves to. That stored length is zero if the bank is free. An endpoint reset pulse or an endpoint disable returns all of this state to empty. Packet memory, the protocol engine and control-transfer decoding sit outside the block.

Top module: `ep_bank_tracker`

## Requirements
- R1: The current bank index (`cur_bank`) is never 3 and stays below the configured bank count. The configured count is `cfg_banks`, where a value of 0 or 1 means one bank. The index wraps from the last configured bank back to 0.
- R2: In IN mode (`cfg_dir_in`=1), a `usr_pkt_ready` pulse with fewer busy banks than configured does three things on the next cycle. It stores the live byte count as the current bank's length, raises `busy_cnt` by one and moves `cur_bank` to the next bank. The live byte count then shows the stored length of that next bank, or 0 if that bank is free.
- R3: In IN mode, a `bus_in_done` pulse while `busy_cnt`>0 frees the oldest busy bank and lowers `busy_cnt` by one. If the freed bank is the current bank, the byte count becomes 0.
- R4: In IN mode, a `bus_in_token` seen while `busy_cnt`=0 makes `hs_nak` 1 on the next cycle. When a bank is busy, the token gives `hs_nak`=0.
- R5: In OUT mode (`cfg_dir_in`=0), a `bus_out_pkt` with free banks stores `bus_out_len` into bank (`cur_bank`+`busy_cnt`) modulo the bank count and raises `busy_cnt` by one. If no bank was busy, `byte_cnt` takes that length.
- R6: In OUT mode, a `bus_out_pkt` or `bus_ping` while every bank is busy makes `hs_nak` 1 on the next cycle and sets `nak_out` until cleared. `busy_cnt`, `cur_bank` and `byte_cnt` stay unchanged.
- R7: In OUT mode, a `usr_release` pulse while `busy_cnt`>0 lowers `busy_cnt` by one and moves `cur_bank` to the next bank. The byte count is reloaded with that bank's stored length, or 0 if the bank is free.
- R8: `usr_wr_byte` adds one to `byte_cnt` in IN mode. `usr_rd_byte` subtracts one in OUT mode.
- R9: Some user requests are ignored and set the sticky `usr_err`: `usr_pkt_ready` with all banks busy, `usr_release` with no bank busy, and `usr_rd_byte` at a byte count of 0. `busy_cnt` and `byte_cnt` stay as they were.
- R10: `ep_rst_pulse` or `ep_disable` clears several things on the next cycle: `cur_bank`, `busy_cnt`, `byte_cnt`, `nak_out`, `usr_err` and every stored length. This clear takes priority over every other request.
- R11: In the same cycle, an accepted OUT packet and an accepted `usr_release` both take effect. `busy_cnt` stays the same, and the byte count shows the length that has just arrived if it went into the bank that becomes current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_banks | input | 2 | Number of banks (0 or 1 = one, 2, 3) |
| ep_rst_pulse | input | 1 | Endpoint reset pulse |
| ep_disable | input | 1 | Endpoint disable, clears state while high |
| usr_wr_byte | input | 1 | Firmware wrote one byte (IN) |
| usr_rd_byte | input | 1 | Firmware read one byte (OUT) |
| usr_pkt_ready | input | 1 | Firmware marks current bank ready to send (IN) |
| usr_release | input | 1 | Firmware releases current received bank (OUT) |
| bus_in_token | input | 1 | Host IN token seen |
| bus_in_done | input | 1 | IN packet sent and acknowledged |
| bus_out_pkt | input | 1 | OUT packet received |
| bus_ping | input | 1 | PING token seen |
| bus_out_len | input | CNT_W | Length of the received OUT packet |
| cur_bank | output | 2 | Current bank index |
| busy_cnt | output | 2 | Number of busy banks |
| byte_cnt | output | CNT_W | Live byte count of the current bank |
| nak_out | output | 1 | Sticky: NAK returned to OUT or PING |
| hs_nak | output | 1 | One-cycle NAK decision for the previous cycle's token |
| usr_err | output | 1 | Sticky: an illegal user request was ignored |

## Verification
The hardest case to reach is the one where the bank being reloaded is also the bank written in the same cycle. One example is a release that happens together with an OUT packet landing in the bank about to become current. Another is a one-bank IN endpoint, where the next bank is the current bank. The stimulus reaches the first case by filling a two-bank OUT endpoint, releasing one bank, and then pulsing an OUT packet and a release in the same cycle. It reaches the second by running a one-bank IN endpoint through a full fill, commit and send sequence. The full-bank NAK paths come from overfilling the endpoint before releasing anything.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  localparam int BANK_IDX_W = 2;
  localparam int BANK_MAX   = 3;
  typedef logic [BANK_IDX_W-1:0] bank_idx_t;

  function automatic bank_idx_t bank_add(bank_idx_t a, bank_idx_t b, bank_idx_t n);
    logic [BANK_IDX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[BANK_IDX_W-1:0];
  endfunction

  function automatic bank_idx_t bank_sub(bank_idx_t a, bank_idx_t b, bank_idx_t n);
    logic [BANK_IDX_W:0] s;
    s = {1'b0, a} + {1'b0, n} - {1'b0, b};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[BANK_IDX_W-1:0];
  endfunction
endpackage

// File: rtl/ep_bank_index.sv
module ep_bank_index
  import ep_bank_pkg::*;
(
  input  bank_idx_t cfg_banks,
  input  bank_idx_t cur,
  input  bank_idx_t busy,
  output bank_idx_t nb,
  output bank_idx_t nxt,
  output bank_idx_t fill,
  output bank_idx_t oldest
);
  always_comb begin
    nb     = (cfg_banks == '0) ? bank_idx_t'(1) : cfg_banks;
    nxt    = bank_add(cur, bank_idx_t'(1), nb);
    fill   = bank_add(cur, busy, nb);
    oldest = bank_sub(cur, busy, nb);
  end
endmodule

// File: rtl/ep_bank_len_mem.sv
module ep_bank_len_mem
  import ep_bank_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int DEPTH = BANK_MAX
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             we_u,
  input  bank_idx_t        wa_u,
  input  logic [CNT_W-1:0] wd_u,
  input  logic             we_b,
  input  bank_idx_t        wa_b,
  input  logic [CNT_W-1:0] wd_b,
  input  bank_idx_t        ra,
  output logic [CNT_W-1:0] rd
);
  logic [CNT_W-1:0] len_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (clr)                                 len_q[g] <= '0;
      else if (we_u && wa_u == bank_idx_t'(g)) len_q[g] <= wd_u;
      else if (we_b && wa_b == bank_idx_t'(g)) len_q[g] <= wd_b;
    end
  end

  // read of the bank about to become current, with same-cycle write forwarding
  always_comb begin
    rd = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ra == bank_idx_t'(i)) rd = len_q[i];
    if (we_b && wa_b == ra) rd = wd_b;
    if (we_u && wa_u == ra) rd = wd_u;
  end
endmodule

// File: rtl/ep_bank_tracker.sv
module ep_bank_tracker
  import ep_bank_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_dir_in,
  input  logic [1:0]       cfg_banks,
  input  logic             ep_rst_pulse,
  input  logic             ep_disable,
  input  logic             usr_wr_byte,
  input  logic             usr_rd_byte,
  input  logic             usr_pkt_ready,
  input  logic             usr_release,
  input  logic             bus_in_token,
  input  logic             bus_in_done,
  input  logic             bus_out_pkt,
  input  logic             bus_ping,
  input  logic [CNT_W-1:0] bus_out_len,
  output logic [1:0]       cur_bank,
  output logic [1:0]       busy_cnt,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             nak_out,
  output logic             hs_nak,
  output logic             usr_err
);
  bank_idx_t nb, nxt, fill, oldest;
  logic [CNT_W-1:0] reload_len;
  logic ep_clr, pkt_ok, pkt_bad, done_ok, in_nak, out_ok, out_nak;
  logic rel_ok, rel_bad, rd_ok, rd_bad, wr_ok, adv;
  logic u_we, b_we;
  bank_idx_t b_wa;
  logic [CNT_W-1:0] u_wd, b_wd, byte_nxt;
  bank_idx_t busy_nxt;

  ep_bank_index u_idx (
    .cfg_banks (cfg_banks),
    .cur       (cur_bank),
    .busy      (busy_cnt),
    .nb        (nb),
    .nxt       (nxt),
    .fill      (fill),
    .oldest    (oldest)
  );

  always_comb begin
    ep_clr  = ep_rst_pulse | ep_disable;
    pkt_ok  =  cfg_dir_in & usr_pkt_ready & (busy_cnt <  nb);
    pkt_bad =  cfg_dir_in & usr_pkt_ready & (busy_cnt >= nb);
    done_ok =  cfg_dir_in & bus_in_done   & (busy_cnt != '0);
    in_nak  =  cfg_dir_in & bus_in_token  & (busy_cnt == '0);
    out_ok  = !cfg_dir_in & bus_out_pkt   & (busy_cnt <  nb);
    out_nak = !cfg_dir_in & (bus_out_pkt | bus_ping) & (busy_cnt >= nb);
    rel_ok  = !cfg_dir_in & usr_release   & (busy_cnt != '0);
    rel_bad = !cfg_dir_in & usr_release   & (busy_cnt == '0);
    rd_ok   = !cfg_dir_in & usr_rd_byte & !usr_release & (byte_cnt != '0);
    rd_bad  = !cfg_dir_in & usr_rd_byte & !usr_release & (byte_cnt == '0);
    wr_ok   =  cfg_dir_in & usr_wr_byte & !usr_pkt_ready;
    adv     = pkt_ok | rel_ok;
    // user port: commit length on ready, zero the bank on release
    u_we    = adv;
    u_wd    = pkt_ok ? byte_cnt : '0;
    // bus port: record OUT length, zero the bank freed by IN completion
    b_we    = out_ok | done_ok;
    b_wa    = cfg_dir_in ? oldest : fill;
    b_wd    = out_ok ? bus_out_len : '0;
  end

  ep_bank_len_mem #(.CNT_W(CNT_W), .DEPTH(BANK_MAX)) u_mem (
    .clk  (clk),
    .clr  (rst | ep_clr),
    .we_u (u_we),
    .wa_u (cur_bank),
    .wd_u (u_wd),
    .we_b (b_we),
    .wa_b (b_wa),
    .wd_b (b_wd),
    .ra   (nxt),
    .rd   (reload_len)
  );

  always_comb begin
    busy_nxt = busy_cnt + bank_idx_t'(pkt_ok | out_ok) - bank_idx_t'(done_ok | rel_ok);
    if (adv)                             byte_nxt = reload_len;
    else if (done_ok && oldest == cur_bank) byte_nxt = '0;
    else if (out_ok && busy_cnt == '0)   byte_nxt = bus_out_len;
    else if (wr_ok)                      byte_nxt = byte_cnt + 1'b1;
    else if (rd_ok)                      byte_nxt = byte_cnt - 1'b1;
    else                                 byte_nxt = byte_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst || ep_clr) begin
      cur_bank <= '0;
      busy_cnt <= '0;
      byte_cnt <= '0;
      nak_out  <= 1'b0;
      hs_nak   <= 1'b0;
      usr_err  <= 1'b0;
    end else begin
      if (adv) cur_bank <= nxt;
      busy_cnt <= busy_nxt;
      byte_cnt <= byte_nxt;
      hs_nak   <= in_nak | out_nak;
      if (out_nak) nak_out <= 1'b1;
      if (pkt_bad | rel_bad | rd_bad) usr_err <= 1'b1;
    end
  end
endmodule

// File: rtl/ep_bank_tracker_chk.sv
module ep_bank_tracker_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_dir_in,
  input logic [1:0]       cfg_banks,
  input logic             ep_rst_pulse,
  input logic             ep_disable,
  input logic             usr_pkt_ready,
  input logic             bus_in_token,
  input logic             bus_in_done,
  input logic             bus_out_pkt,
  input logic [1:0]       cur_bank,
  input logic [1:0]       busy_cnt,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             nak_out,
  input logic             hs_nak,
  input logic             usr_err
);
  logic [1:0] nb;
  logic clr_in;
  assign nb     = (cfg_banks == 2'd0) ? 2'd1 : cfg_banks;
  assign clr_in = ep_rst_pulse | ep_disable;

  p_bank_valid_r1: assert property (@(posedge clk) disable iff (rst)
    cur_bank != 2'd3);

  p_busy_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr_in && cfg_dir_in && usr_pkt_ready && busy_cnt < nb && !bus_in_done)
    |=> busy_cnt == $past(busy_cnt) + 2'd1);

  p_in_nak_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr_in && cfg_dir_in && bus_in_token && busy_cnt == 2'd0) |=> hs_nak);

  p_full_nak_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_in && !cfg_dir_in && bus_out_pkt && busy_cnt == nb) |=> (hs_nak && nak_out));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (usr_err && !clr_in) |=> usr_err);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr_in |=> (cur_bank == 2'd0 && busy_cnt == 2'd0 && byte_cnt == '0 && !nak_out && !usr_err));
endmodule

bind ep_bank_tracker ep_bank_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_dir_in    (cfg_dir_in),
  .cfg_banks     (cfg_banks),
  .ep_rst_pulse  (ep_rst_pulse),
  .ep_disable    (ep_disable),
  .usr_pkt_ready (usr_pkt_ready),
  .bus_in_token  (bus_in_token),
  .bus_in_done   (bus_in_done),
  .bus_out_pkt   (bus_out_pkt),
  .cur_bank      (cur_bank),
  .busy_cnt      (busy_cnt),
  .byte_cnt      (byte_cnt),
  .nak_out       (nak_out),
  .hs_nak        (hs_nak),
  .usr_err       (usr_err)
);

// File: tb/tb_ep_bank_tracker.sv
`timescale 1ns/100ps
module tb_ep_bank_tracker;
  localparam int CNT_W = 11;

  logic clk = 1'b0;
  logic rst;
  logic cfg_dir_in;
  logic [1:0] cfg_banks;
  logic ep_rst_pulse, ep_disable;
  logic usr_wr_byte, usr_rd_byte, usr_pkt_ready, usr_release;
  logic bus_in_token, bus_in_done, bus_out_pkt, bus_ping;
  logic [CNT_W-1:0] bus_out_len;
  logic [1:0] cur_bank, busy_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic nak_out, hs_nak, usr_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ep_bank_tracker #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cfg_dir_in(cfg_dir_in), .cfg_banks(cfg_banks),
    .ep_rst_pulse(ep_rst_pulse), .ep_disable(ep_disable),
    .usr_wr_byte(usr_wr_byte), .usr_rd_byte(usr_rd_byte),
    .usr_pkt_ready(usr_pkt_ready), .usr_release(usr_release),
    .bus_in_token(bus_in_token), .bus_in_done(bus_in_done),
    .bus_out_pkt(bus_out_pkt), .bus_ping(bus_ping), .bus_out_len(bus_out_len),
    .cur_bank(cur_bank), .busy_cnt(busy_cnt), .byte_cnt(byte_cnt),
    .nak_out(nak_out), .hs_nak(hs_nak), .usr_err(usr_err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ep_rst_pulse = 0; ep_disable = 0;
    usr_wr_byte = 0; usr_rd_byte = 0; usr_pkt_ready = 0; usr_release = 0;
    bus_in_token = 0; bus_in_done = 0; bus_out_pkt = 0; bus_ping = 0;
  endtask

  // one clock: inputs set beforehand at negedge, outputs seen at next negedge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic state(string tag, int cb, int bc, int by);
    chk({tag, " cur_bank"}, cur_bank, cb);
    chk({tag, " busy_cnt"}, busy_cnt, bc);
    chk({tag, " byte_cnt"}, byte_cnt, by);
  endtask

  task automatic ep_reset(bit dir_in, logic [1:0] banks);
    ep_rst_pulse = 1; cyc();
    cfg_dir_in = dir_in; cfg_banks = banks;
  endtask

  task automatic wr_bytes(int n);
    for (int i = 0; i < n; i++) begin usr_wr_byte = 1; cyc(); end
  endtask

  task automatic t_reset();
    state("R10 reset", 0, 0, 0);
    chk("R10 reset nak_out", nak_out, 0);
    chk("R10 reset usr_err", usr_err, 0);
    chk("R4 reset hs_nak", hs_nak, 0);
  endtask

  task automatic t_in_three();
    ep_reset(1'b1, 2'd3);
    wr_bytes(5);
    chk("R8 write count", byte_cnt, 5);
    usr_pkt_ready = 1; cyc();
    state("R2 ready bank0", 1, 1, 0);
    wr_bytes(3);
    usr_pkt_ready = 1; cyc();
    state("R2 ready bank1", 2, 2, 0);
    wr_bytes(7);
    usr_pkt_ready = 1; cyc();
    state("R1 wrap to bank0, R2 reload stored 5", 0, 3, 5);
    usr_pkt_ready = 1; cyc();
    state("R9 ready when full ignored", 0, 3, 5);
    chk("R9 err set", usr_err, 1);
    bus_in_token = 1; cyc();
    chk("R4 token with busy bank no nak", hs_nak, 0);
    bus_in_done = 1; cyc();
    state("R3 free oldest=current", 0, 2, 0);
    bus_in_done = 1; cyc();
    state("R3 free second", 0, 1, 0);
    bus_in_done = 1; cyc();
    state("R3 free third", 0, 0, 0);
    bus_in_token = 1; cyc();
    chk("R4 token empty nak", hs_nak, 1);
    cyc();
    chk("R4 nak is one cycle", hs_nak, 0);
    chk("R9 err sticky", usr_err, 1);
    ep_rst_pulse = 1; cyc();
    chk("R10 ep reset clears err", usr_err, 0);
  endtask

  task automatic t_out_two();
    ep_reset(1'b0, 2'd2);
    bus_out_pkt = 1; bus_out_len = 10; cyc();
    state("R5 first out pkt", 0, 1, 10);
    usr_rd_byte = 1; cyc();
    usr_rd_byte = 1; cyc();
    chk("R8 read count", byte_cnt, 8);
    bus_out_pkt = 1; bus_out_len = 20; cyc();
    state("R5 second out pkt", 0, 2, 8);
    bus_out_pkt = 1; bus_out_len = 30; cyc();
    chk("R6 full out nak", hs_nak, 1);
    chk("R6 nak_out set", nak_out, 1);
    state("R6 state unchanged", 0, 2, 8);
    bus_ping = 1; cyc();
    chk("R6 ping full nak", hs_nak, 1);
    usr_release = 1; cyc();
    state("R7 release reload 20", 1, 1, 20);
    bus_out_pkt = 1; bus_out_len = 40; usr_release = 1; cyc();
    state("R11 simultaneous out and release", 0, 1, 40);
    chk("R6 nak_out sticky", nak_out, 1);
    usr_release = 1; cyc();
    state("R7 release to free bank", 1, 0, 0);
    chk("R9 err clear before", usr_err, 0);
    usr_release = 1; cyc();
    state("R9 release empty ignored", 1, 0, 0);
    chk("R9 release empty err", usr_err, 1);
    usr_rd_byte = 1; cyc();
    chk("R9 read at zero ignored", byte_cnt, 0);
    ep_disable = 1; cyc();
    chk("R10 disable clears nak_out", nak_out, 0);
    state("R10 disable clears state", 0, 0, 0);
  endtask

  task automatic t_in_single();
    ep_reset(1'b1, 2'd1);
    wr_bytes(4);
    usr_pkt_ready = 1; cyc();
    state("R1 one bank stays 0, R2 reload", 0, 1, 4);
    usr_wr_byte = 1; usr_pkt_ready = 1; cyc();
    chk("R9 ready full one bank err", usr_err, 1);
    bus_in_done = 1; cyc();
    state("R3 single bank freed", 0, 0, 0);
  endtask

  task automatic t_cfg_zero();
    ep_reset(1'b0, 2'd0);
    bus_out_pkt = 1; bus_out_len = 9; cyc();
    state("R1 cfg0 one bank fill", 0, 1, 9);
    bus_out_pkt = 1; bus_out_len = 3; cyc();
    chk("R1 cfg0 second pkt nak", hs_nak, 1);
    chk("R6 cfg0 busy held", busy_cnt, 1);
    usr_release = 1; cyc();
    state("R7 cfg0 release wraps", 0, 0, 0);
  endtask

  initial begin
    idle_inputs();
    rst = 1; cfg_dir_in = 1; cfg_banks = 2'd3; bus_out_len = '0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_in_three();
    t_out_two();
    t_in_single();
    t_cfg_zero();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule